// File: doc/BRIEF.md
# Four-Phase Stored-Program Sequencer

This block is the control core of a tiny processor that shares one memory between its program and its data. It walks a fixed four-step loop for every instruction. First it reads the instruction word at the program counter and moves the counter on by one word. Next it captures that word and picks up two register operands. Then it computes a result. Last it writes that result back to memory, at a byte address carried inside the instruction. No result ever goes back to a register, so every instruction costs exactly one memory read and one memory write.

The register file holds four 32-bit entries. It is loaded through a preload port while the sequencer is held in reset, and it is read-only once the sequencer runs. The memory has a one-cycle read latency: the word asked for in one cycle is on `mem_rdata` in the next. A halt opcode parks the sequencer in an idle state until the next reset.

Top module: `stored_prog_seq`

## Requirements
- R1: While `rst_n` is low, `mem_rd`, `mem_wr` and `halted` are 0. In the first cycle after `rst_n` rises, a read is issued at address 0.
- R2: Each instruction takes four cycles: read, capture, compute, write. `mem_rd` is a one-cycle pulse, `mem_wr` follows exactly three cycles after it as a one-cycle pulse, and the two strobes are never high together. The instruction word is taken from `mem_rdata` in the cycle after the read.
- R3: Successive instruction reads go to addresses 0, 4, 8, and so on. Each read is 4 bytes above the one before.
- R4: The instruction word has this layout. Bits 31:28 are the opcode. Bits 27:26 select operand register A and bits 25:24 select operand register B. Bits 23:0 give the result byte address.
- R5: Opcode 0 writes A+B, modulo 2^32.
- R6: Opcode 1 writes A-B, modulo 2^32.
- R7: Opcode 2 writes A|B and opcode 3 writes A&B.
- R8: In the write cycle, `mem_addr` equals instruction bits 23:0 and `mem_wdata` equals the result.
- R9: Opcode 15 issues no write and no further reads. `halted` goes high and stays high until reset.
- R10: Opcodes 4 to 14 are not halts. They run all four phases and write the value 0.
- R11: A preload (`rf_ld_en` with `rf_ld_sel` and `rf_ld_val`) writes the register file only while `rst_n` is low. Preload attempts while the sequencer runs leave the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_ld_en | input | 1 | Register preload strobe, honoured only in reset |
| rf_ld_sel | input | 2 | Register preload index |
| rf_ld_val | input | 32 | Register preload value |
| mem_addr | output | 24 | Byte address: PC on reads, result address on writes |
| mem_rd | output | 1 | Read command pulse |
| mem_wr | output | 1 | Write command pulse |
| mem_wdata | output | 32 | Result value on writes |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| halted | output | 1 | Sequencer stopped by a halt opcode |

## Verification
The bench targets several boundary cases and the failure each one exposes:
- Wrapping arithmetic, where 3-4 and 0xFFFFFFFF+4 must give 0xFFFFFFFF and 3. A design that saturates or truncates the result would write the wrong value.
- Register-select fields that swap A and B. A non-commutative subtract would then store the negated value.
- An undefined opcode. A design that halts on it, or passes an operand through, would either stop writing or write a nonzero value.
- The halt opcode. A leaky design would emit a stray write or keep fetching after it.
- Preloads attempted during a run. A design that accepts them would corrupt the later results that read that register.
- A result address with high bits set. A design with a truncated address path would drive the wrong upper address bits.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 24;
    localparam int OPC_W  = 4;
    localparam int NREG   = 4;
    localparam int SEL_W  = $clog2(NREG);

    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_OR   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_AND  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_HALT = 4'd15;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_STORE  = 3'd3,
        PH_HALT   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic [ADDR_W-1:0] dst;
    } instr_t;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] opa;
        logic [WORD_W-1:0] opb;
        logic [WORD_W-1:0] res;
    } seq_state_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output instr_t            fields_o
);
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam int SA_LSB  = OPC_LSB - SEL_W;
    localparam int SB_LSB  = SA_LSB - SEL_W;

    always_comb begin
        fields_o.opc   = word_i[WORD_W-1:OPC_LSB];
        fields_o.sel_a = word_i[OPC_LSB-1:SA_LSB];
        fields_o.sel_b = word_i[SA_LSB-1:SB_LSB];
        fields_o.dst   = word_i[ADDR_W-1:0];
    end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
    import seq_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = WORD_W,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wval,
    input  logic [SW-1:0] rsel_a,
    input  logic [SW-1:0] rsel_b,
    output logic [W-1:0]  rval_a,
    output logic [W-1:0]  rval_b
);
    logic [W-1:0] cell_q [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && (wsel == SW'(gi))) begin
                cell_q[gi] <= wval;
            end
        end
    end

    assign rval_a = cell_q[rsel_a];
    assign rval_b = cell_q[rsel_b];
endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [OPC_W-1:0] opc_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic [W-1:0]     y_o
);
    always_comb begin
        unique case (opc_i)
            OPC_ADD: y_o = a_i + b_i;
            OPC_SUB: y_o = a_i - b_i;
            OPC_OR:  y_o = a_i | b_i;
            OPC_AND: y_o = a_i & b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/stored_prog_seq.sv
module stored_prog_seq
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_ld_en,
    input  logic [SEL_W-1:0]  rf_ld_sel,
    input  logic [WORD_W-1:0] rf_ld_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(WORD_W / 8);

    seq_state_t s_d, s_q;

    instr_t            fetched_f, held_f;
    logic [WORD_W-1:0] rf_a, rf_b, alu_y;

    seq_decode u_dec_fetch (.word_i(mem_rdata), .fields_o(fetched_f));
    seq_decode u_dec_held  (.word_i(s_q.ir),    .fields_o(held_f));

    seq_regfile #(.N(NREG), .W(WORD_W)) u_rf (
        .clk    (clk),
        .we     (rf_ld_en && !rst_n),
        .wsel   (rf_ld_sel),
        .wval   (rf_ld_val),
        .rsel_a (fetched_f.sel_a),
        .rsel_b (fetched_f.sel_b),
        .rval_a (rf_a),
        .rval_b (rf_b)
    );

    seq_alu #(.W(WORD_W)) u_alu (
        .opc_i (held_f.opc),
        .a_i   (s_q.opa),
        .b_i   (s_q.opb),
        .y_o   (alu_y)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_FETCH: begin
                s_d.pc    = s_q.pc + PC_STEP;
                s_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                s_d.ir    = mem_rdata;
                s_d.opa   = rf_a;
                s_d.opb   = rf_b;
                s_d.phase = (fetched_f.opc == OPC_HALT) ? PH_HALT : PH_EXEC;
            end
            PH_EXEC: begin
                s_d.res   = alu_y;
                s_d.phase = PH_STORE;
            end
            PH_STORE: s_d.phase = PH_FETCH;
            PH_HALT:  s_d.phase = PH_HALT;
            default:  s_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_FETCH, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_rd    = rst_n && (s_q.phase == PH_FETCH);
    assign mem_wr    = rst_n && (s_q.phase == PH_STORE);
    assign halted    = rst_n && (s_q.phase == PH_HALT);
    assign mem_addr  = (s_q.phase == PH_STORE) ? held_f.dst : s_q.pc;
    assign mem_wdata = s_q.res;
endmodule

// File: rtl/stored_prog_seq_chk.sv
module stored_prog_seq_chk
    import seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              halted
);
    logic [ADDR_W-1:0] last_rd_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            last_rd_q <= '0;
        end else if (mem_rd) begin
            seen_q    <= 1'b1;
            last_rd_q <= mem_addr;
        end
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!mem_rd && !mem_wr && !halted); // R1
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R2
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R2
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 3)); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && seen_q) |-> (mem_addr == last_rd_q + ADDR_W'(4))); // R3
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr)); // R9
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9
endmodule

bind stored_prog_seq stored_prog_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .halted   (halted)
);

// File: tb/stored_prog_seq_tb_top.sv
`timescale 1ns/1ps
module stored_prog_seq_tb_top;
    typedef struct packed {
        logic [31:0] instr;
        logic [23:0] addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 9;
    // registers: r0=3 r1=4 r2=FFFFFFFF r3=0F0F00F0
    localparam vec_t VECS [NV] = '{
        '{32'h01000100, 24'h000100, 32'h00000007},  // R5 add r0,r1
        '{32'h11000104, 24'h000104, 32'hFFFFFFFF},  // R6 sub r0,r1 wraps
        '{32'h09000108, 24'h000108, 32'h00000003},  // R5 add r2,r1 wraps
        '{32'h2D00010C, 24'h00010C, 32'h0F0F00F4},  // R7 or r3,r1
        '{32'h3E000110, 24'h000110, 32'h0F0F00F0},  // R7 and r3,r2
        '{32'h14000114, 24'h000114, 32'h00000001},  // R6 sub r1,r0 (swapped)
        '{32'h71000118, 24'h000118, 32'h00000000},  // R10 undefined opcode
        '{32'h2000011C, 24'h00011C, 32'h00000003},  // R11 or r0,r0 after run-time preload
        '{32'h0FABCDE0, 24'hABCDE0, 32'h1E1E01E0}   // R8 high address bits
    };
    localparam logic [31:0] HALT_WORD = 32'hF0000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_ld_en = 1'b0;
    logic [1:0]  rf_ld_sel = '0;
    logic [31:0] rf_ld_val = '0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, halted;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [64];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_rd = 0;
    int n_wr = 0;
    int last_rd_cyc = 0;
    logic [23:0] last_rd_addr = '0;

    always #2.5 clk = ~clk;

    stored_prog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .rf_ld_en(rf_ld_en), .rf_ld_sel(rf_ld_sel),
        .rf_ld_val(rf_ld_val), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    // memory model: one-cycle read latency, program loaded while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= '0;
            for (int i = 0; i < NV; i++) mem[i] <= VECS[i].instr;
            mem[NV] <= HALT_WORD;
        end else begin
            if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) begin
            n_rd <= n_rd + 1;
            last_rd_cyc <= cyc;
            last_rd_addr <= mem_addr;
        end
        if (mem_wr) n_wr <= n_wr + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        rf_ld_en = 1'b1; rf_ld_sel = sel; rf_ld_val = val;
        @(negedge clk);
        rf_ld_en = 1'b0;
    endtask

    task automatic wait_wr(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (mem_wr) begin ok = 1'b1; break; end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit ok;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 rd in reset", {31'd0, mem_rd}, 32'd0);
        check("R1 wr in reset", {31'd0, mem_wr}, 32'd0);
        check("R1 halted in reset", {31'd0, halted}, 32'd0);
        preload(2'd0, 32'h00000003);  // R11 preload in reset
        preload(2'd1, 32'h00000004);
        preload(2'd2, 32'hFFFFFFFF);
        preload(2'd3, 32'h0F0F00F0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 first read", {31'd0, mem_rd}, 32'd1);
        check("R1 first addr", {8'd0, mem_addr}, 32'd0);
        // R11: attempt preload while running, must be ignored
        @(negedge clk);
        rf_ld_en = 1'b1; rf_ld_sel = 2'd0; rf_ld_val = 32'd100;
        @(negedge clk);
        rf_ld_en = 1'b0;

        for (int i = 0; i < NV; i++) begin
            wait_wr(ok);
            check("R2 write seen", {31'd0, ok}, 32'd1);
            if (!ok) break;
            check("R8 addr", {8'd0, mem_addr}, {8'd0, VECS[i].addr});
            check("R8 data", mem_wdata, VECS[i].data);
            check("R3 fetch addr", {8'd0, last_rd_addr}, 32'(4 * i));
            check("R2 rd-to-wr gap", 32'(cyc - last_rd_cyc), 32'd3);
            check("R2 no read on write", {31'd0, mem_rd}, 32'd0);
        end

        // R9 halt
        repeat (15) @(negedge clk);
        check("R9 halted", {31'd0, halted}, 32'd1);
        check("R9 read count", 32'(n_rd), 32'(NV + 1));
        check("R9 write count", 32'(n_wr), 32'(NV));
        check("R8 memory word", mem[6'h40], 32'h00000007);
        check("R10 memory word", mem[6'h46], 32'h00000000);

        // second reset with new preload, R11 takes effect in reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 halted cleared", {31'd0, halted}, 32'd0);
        preload(2'd0, 32'd10);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 restart addr", {8'd0, mem_addr}, 32'd0);
        wait_wr(ok);
        check("R11 preload used", mem_wdata, 32'd14);
        check("R4 dst field", {8'd0, mem_addr}, 32'h100);
        finish_run();
    end
endmodule